// File: doc/BRIEF.md
# PHY Status Auto-Poll Change Detector

This block watches a PHY status word for changes without host involvement. An interval counter asks an external management-read engine for the status word. It raises a one-cycle request only when polling is enabled, the engine reports idle, and no earlier read is still outstanding. Each returned word is compared with a shadow copy of the previous one, and then the shadow takes the new word.

When the shadow held valid data and the compared bits differ, a sticky change flag is set. The host clears the flag by writing a one. The flag reaches the interrupt output only while the interrupt enable is high.

A configuration bit selects the access method the poller uses. Any change of that bit, in either direction, empties the shadow. The next completed read then only reloads the shadow and never flags a change. A parameter mask can remove individual status bits from the comparison. Masked bits are still stored in the shadow.

Top module: `phy_status_watch`

## Requirements
- R1: After reset, `mgmt_req`, `chg_flag`, `irq_out` and `shadow_vld` are 0, and `shadow_q` is all zeros.
- R2: `mgmt_req` rises only when `cfg_poll_en` is 1, `mgmt_idle` was 1 in the cycle before, and no read is outstanding. It is high for exactly one cycle.
- R3: A read is outstanding from the request until the next `rsp_valid`. While the engine stays idle, the next request rises exactly `cfg_interval`+1 cycles after the edge that accepted the previous response.
- R4: A response accepted while `shadow_vld` is 0 loads `shadow_q` and sets `shadow_vld`. It never sets `chg_flag`.
- R5: Every accepted response is copied into `shadow_q`. If `shadow_vld` was 1 and a compared bit differs from the old shadow, `chg_flag` is 1 after that edge.
- R6: A response equal to the shadow in all compared bits leaves `chg_flag` unchanged.
- R7: When `cfg_method` differs from its value in the previous cycle, `shadow_vld` and `shadow_q` are cleared at the next edge. Any response accepted in that same cycle is discarded.
- R8: `chg_flag` holds until `host_clr` is 1 at an edge, which clears it. If a set and a clear meet in one cycle, the set wins and the flag stays 1.
- R9: `irq_out` equals `chg_flag` AND `irq_en` at all times.
- R10: A `rsp_valid` with no read outstanding is ignored: `shadow_q`, `shadow_vld` and `chg_flag` keep their values.
- R11: Status bits that are 0 in parameter `CMP_MASK` never cause a change, but they are still stored in `shadow_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| cfg_poll_en | input | 1 | Enables automatic polling |
| cfg_interval | input | CNT_W | Idle cycles between reads |
| cfg_method | input | 1 | Access-method select; any change empties the shadow |
| irq_en | input | 1 | Lets the change flag drive `irq_out` |
| host_clr | input | 1 | Write-1 strobe that clears the change flag |
| mgmt_idle | input | 1 | Management engine ready for a read |
| mgmt_req | output | 1 | One-cycle read request |
| rsp_valid | input | 1 | Read data strobe from the engine |
| rsp_data | input | DATA_W | Status word returned by the engine |
| chg_flag | output | 1 | Sticky status-change flag |
| irq_out | output | 1 | Gated interrupt |
| shadow_q | output | DATA_W | Stored previous status word |
| shadow_vld | output | 1 | Shadow holds a valid word |

## Verification
The bench builds the block with a 16-bit status word, an 8-bit interval counter and a compare mask of 0x7FFF, and it runs with an interval of 5. The short interval keeps the exact request spacing of R3 and the many back-to-back polls cheap in cycles. The cleared top mask bit makes R11 reachable, because a change in that bit alone must raise no flag while it still lands in the shadow.

// File: rtl/pstw_pkg.sv
package pstw_pkg;

   // Which of a simultaneous set and host clear survives in the change flag
   typedef enum logic {
      PRIO_CLEAR = 1'b0,
      PRIO_SET   = 1'b1
   } clr_prio_e;

   localparam int MAX_CNT_W  = 32;
   localparam int MAX_DATA_W = 64;

endpackage

// File: rtl/pstw_poll_timer.sv
module pstw_poll_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             idle,
   input  logic             done,
   input  logic [CNT_W-1:0] interval,
   output logic             req,
   output logic             busy
);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             req_q;
   logic             fire;
   logic             cnt_zero;

   assign cnt_zero = (cnt_q == '0);
   assign fire     = en && !busy_q && cnt_zero && idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         req_q <= fire;
         if (!en || fire) begin
            cnt_q <= interval;
         end else if (!busy_q && !cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
         end
         if (fire) begin
            busy_q <= 1'b1;
         end else if (done) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign req  = req_q;
   assign busy = busy_q;

   // R2: a request lasts a single cycle
   a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req);

   // R2: a request follows a cycle in which the engine was idle
   a_r2_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $past(idle) && $past(en));

   // R3: while a read is outstanding the counter is frozen
   a_r3_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && en && !done) |=> $stable(cnt_q));

endmodule

// File: rtl/pstw_shadow_cmp.sv
module pstw_shadow_cmp #(
   parameter int               DATA_W   = 16,
   parameter logic [DATA_W-1:0] CMP_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] data,
   input  logic              method,
   output logic [DATA_W-1:0] shadow,
   output logic              vld,
   output logic              set_chg,
   output logic              meth_chg
);

   logic [DATA_W-1:0] shadow_q;
   logic              vld_q;
   logic              meth_q;
   logic [DATA_W-1:0] diff;

   // Per-bit comparator; masked-out bits are tied off
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (CMP_MASK[i]) begin : g_cmp
         assign diff[i] = data[i] ^ shadow_q[i];
      end else begin : g_skip
         assign diff[i] = 1'b0;
      end
   end

   assign meth_chg = (method != meth_q);
   assign set_chg  = accept && vld_q && !meth_chg && (|diff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         vld_q    <= 1'b0;
         meth_q   <= 1'b0;
      end else begin
         meth_q <= method;
         if (meth_chg) begin
            shadow_q <= '0;
            vld_q    <= 1'b0;
         end else if (accept) begin
            shadow_q <= data;
            vld_q    <= 1'b1;
         end
      end
   end

   assign shadow = shadow_q;
   assign vld    = vld_q;

   // R7: a method change leaves the shadow empty
   a_r7_inval: assert property (@(posedge clk) disable iff (!rst_n)
      meth_chg |=> (!vld_q && shadow_q == '0));

   // R4: the shadow becomes valid only through an accepted response
   a_r4_vld_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vld_q) |-> $past(accept));

endmodule

// File: rtl/pstw_chg_irq.sv
module pstw_chg_irq
   import pstw_pkg::*;
#(
   parameter clr_prio_e PRIO = PRIO_SET
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic en,
   output logic flag,
   output logic irq
);

   logic flag_q;
   logic flag_d;

   if (PRIO == PRIO_SET) begin : g_set_wins
      assign flag_d = set | (flag_q & ~clr);
   end else begin : g_clr_wins
      assign flag_d = ~clr & (set | flag_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else begin
         flag_q <= flag_d;
      end
   end

   assign flag = flag_q;
   assign irq  = flag_q & en;

   // R8: the flag is sticky until the host clears it
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);

   // R8: the flag rises only because of a detected change
   a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(set));

endmodule

// File: rtl/phy_status_watch.sv
module phy_status_watch
   import pstw_pkg::*;
#(
   parameter int                DATA_W   = 16,
   parameter int                CNT_W    = 16,
   parameter logic [DATA_W-1:0] CMP_MASK = '1,
   parameter clr_prio_e         PRIO     = PRIO_SET
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_poll_en,
   input  logic [CNT_W-1:0]  cfg_interval,
   input  logic              cfg_method,
   input  logic              irq_en,
   input  logic              host_clr,
   input  logic              mgmt_idle,
   output logic              mgmt_req,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              chg_flag,
   output logic              irq_out,
   output logic [DATA_W-1:0] shadow_q,
   output logic              shadow_vld
);

   if (DATA_W < 1 || DATA_W > MAX_DATA_W) begin : g_bad_data_w
      $error("phy_status_watch: DATA_W out of range");
   end
   if (CNT_W < 1 || CNT_W > MAX_CNT_W) begin : g_bad_cnt_w
      $error("phy_status_watch: CNT_W out of range");
   end
   if (CMP_MASK == '0) begin : g_bad_mask
      $error("phy_status_watch: CMP_MASK compares no bit");
   end

   logic busy;
   logic accept;
   logic set_chg;
   logic meth_chg;

   assign accept = rsp_valid && busy;

   pstw_poll_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_poll_en),
      .idle     (mgmt_idle),
      .done     (accept),
      .interval (cfg_interval),
      .req      (mgmt_req),
      .busy     (busy)
   );

   pstw_shadow_cmp #(
      .DATA_W   (DATA_W),
      .CMP_MASK (CMP_MASK)
   ) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .data     (rsp_data),
      .method   (cfg_method),
      .shadow   (shadow_q),
      .vld      (shadow_vld),
      .set_chg  (set_chg),
      .meth_chg (meth_chg)
   );

   pstw_chg_irq #(
      .PRIO(PRIO)
   ) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_chg),
      .clr   (host_clr),
      .en    (irq_en),
      .flag  (chg_flag),
      .irq   (irq_out)
   );

   // R4: a response arriving with an empty shadow cannot raise the flag
   a_r4_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !shadow_vld && !chg_flag) |=> !chg_flag);

   // R5: an accepted response with no method change leaves a valid shadow
   a_r5_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !meth_chg) |=> (shadow_vld && shadow_q == $past(rsp_data)));

   // R10: a stray response does not touch the shadow
   a_r10_stray: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !busy && !meth_chg) |=> ($stable(shadow_q) && $stable(shadow_vld)));

   // R9: the interrupt is never high without the flag
   a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> chg_flag);

endmodule

// File: tb/phy_status_watch_tb_top.sv
module phy_status_watch_tb_top;

   localparam int DW = 16;
   localparam int CW = 8;
   localparam logic [DW-1:0] MASK = 16'h7FFF;
   localparam int IVAL = 5;
   localparam int WD_LIMIT = 50000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_poll_en;
   logic [CW-1:0] cfg_interval;
   logic          cfg_method;
   logic          irq_en;
   logic          host_clr;
   logic          mgmt_idle;
   logic          mgmt_req;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          chg_flag;
   logic          irq_out;
   logic [DW-1:0] shadow_q;
   logic          shadow_vld;

   int n_checks = 0;
   int n_errs   = 0;
   int cyc      = 0;
   int pend     = 0;
   int last_req = 0;
   bit done     = 0;

   always #2.5 clk = ~clk;

   phy_status_watch #(
      .DATA_W   (DW),
      .CNT_W    (CW),
      .CMP_MASK (MASK)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_poll_en  (cfg_poll_en),
      .cfg_interval (cfg_interval),
      .cfg_method   (cfg_method),
      .irq_en       (irq_en),
      .host_clr     (host_clr),
      .mgmt_idle    (mgmt_idle),
      .mgmt_req     (mgmt_req),
      .rsp_valid    (rsp_valid),
      .rsp_data     (rsp_data),
      .chg_flag     (chg_flag),
      .irq_out      (irq_out),
      .shadow_q     (shadow_q),
      .shadow_vld   (shadow_vld)
   );

   // Request monitor: samples just after each edge
   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1;
      if (mgmt_req) begin
         pend     = pend + 1;
         last_req = cyc;
      end
   end

   // Watchdog
   always @(posedge clk) begin
      if (cyc >= WD_LIMIT && !done) begin
         done = 1;
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WD_LIMIT);
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic chk_eq(input string rq, input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, rq, act, exp);
   endtask

   // Wait for a request, answer it, return at the negedge after acceptance
   task automatic poll(input logic [DW-1:0] d, output int req_at);
      int guard = 0;
      while (pend == 0 && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      if (pend == 0) begin
         chk(1'b0, "R2 request timeout", 0, 1);
      end else begin
         pend = pend - 1;
      end
      req_at = last_req;
      rsp_valid = 1'b1;
      rsp_data  = d;
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   task automatic clear_flag();
      host_clr = 1'b1;
      @(negedge clk);
      host_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk_eq("R1 mgmt_req", mgmt_req, 0);
      chk_eq("R1 chg_flag", chg_flag, 0);
      chk_eq("R1 irq_out", irq_out, 0);
      chk_eq("R1 shadow_vld", shadow_vld, 0);
      chk_eq("R1 shadow_q", shadow_q, 0);
   endtask

   task automatic t_first_and_equal();
      int t;
      poll(16'h1234, t);
      chk_eq("R4 first no flag", chg_flag, 0);
      chk_eq("R4 vld set", shadow_vld, 1);
      chk_eq("R5 shadow loaded", shadow_q, 16'h1234);
      poll(16'h1234, t);
      chk_eq("R6 equal no flag", chg_flag, 0);
   endtask

   task automatic t_change_irq();
      int t;
      irq_en = 1'b0;
      poll(16'h1235, t);
      chk_eq("R5 change sets flag", chg_flag, 1);
      chk_eq("R5 shadow updated", shadow_q, 16'h1235);
      chk_eq("R9 gated off", irq_out, 0);
      irq_en = 1'b1;
      #1;
      chk_eq("R9 gated on", irq_out, 1);
      poll(16'h1235, t);
      chk_eq("R8 sticky", chg_flag, 1);
      clear_flag();
      chk_eq("R8 cleared", chg_flag, 0);
      chk_eq("R9 irq follows", irq_out, 0);
   endtask

   task automatic t_set_wins();
      int guard = 0;
      while (pend == 0 && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      pend = pend - 1;
      rsp_valid = 1'b1;
      rsp_data  = 16'h0001;
      host_clr  = 1'b1;
      @(negedge clk);
      rsp_valid = 1'b0;
      host_clr  = 1'b0;
      chk_eq("R8 set wins over clear", chg_flag, 1);
      clear_flag();
   endtask

   task automatic t_mask();
      int t;
      poll(16'h8001, t);
      chk_eq("R11 masked bit no flag", chg_flag, 0);
      chk_eq("R11 masked bit stored", shadow_q, 16'h8001);
   endtask

   task automatic t_interval();
      int t0;
      int t1;
      poll(16'h8001, t0);
      poll(16'h8001, t1);
      chk_eq("R3 request spacing", t1 - t0, IVAL + 2);
   endtask

   task automatic t_idle();
      int t;
      int seen = 0;
      poll(16'h8001, t);
      mgmt_idle = 1'b0;
      for (int i = 0; i < 4 * IVAL; i++) begin
         @(negedge clk);
         if (pend != 0) seen++;
      end
      chk_eq("R2 no request while busy engine", seen, 0);
      mgmt_idle = 1'b1;
      poll(16'h8001, t);
      chk_eq("R2 single-cycle request", mgmt_req, 0);
   endtask

   task automatic t_stray();
      int t;
      poll(16'h8001, t);
      cfg_poll_en = 1'b0;
      @(negedge clk);
      rsp_valid = 1'b1;
      rsp_data  = 16'h0FFF;
      @(negedge clk);
      rsp_valid = 1'b0;
      chk_eq("R10 stray shadow", shadow_q, 16'h8001);
      chk_eq("R10 stray flag", chg_flag, 0);
      chk_eq("R10 stray vld", shadow_vld, 1);
      cfg_poll_en = 1'b1;
   endtask

   task automatic t_method();
      int t;
      cfg_method = 1'b1;
      @(negedge clk);
      chk_eq("R7 vld cleared", shadow_vld, 0);
      chk_eq("R7 shadow cleared", shadow_q, 0);
      poll(16'h0BAD, t);
      chk_eq("R7 first after change quiet", chg_flag, 0);
      chk_eq("R7 reloaded", shadow_vld, 1);
      poll(16'h0BAE, t);
      chk_eq("R7 later change flags", chg_flag, 1);
      clear_flag();
      cfg_method = 1'b0;
      @(negedge clk);
      chk_eq("R7 back change clears vld", shadow_vld, 0);
      poll(16'h5555, t);
      chk_eq("R7 back change quiet", chg_flag, 0);
   endtask

   initial begin
      rst_n        = 1'b0;
      cfg_poll_en  = 1'b0;
      cfg_interval = CW'(IVAL);
      cfg_method   = 1'b0;
      irq_en       = 1'b0;
      host_clr     = 1'b0;
      mgmt_idle    = 1'b1;
      rsp_valid    = 1'b0;
      rsp_data     = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      cfg_poll_en = 1'b1;
      t_first_and_equal();
      t_change_irq();
      t_set_wins();
      t_mask();
      t_interval();
      t_idle();
      t_stray();
      t_method();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule